// File: doc/BRIEF.md
# Selectable Rounding Register File and Adder

This block sits after a filter accumulator. It holds a bank of sixteen 32-bit rounding constants and adds the chosen one to the 32-bit accumulator result. A 4-bit select picks the constant on every cycle. The sum leaves the block through a register, so each result appears one clock after its operands. The addition wraps modulo 2^32 and does not saturate. Rounding is switched off by loading a constant of zero and selecting it.

Constants are written through a 12-bit configuration port. A write is a header word followed by four data words, and each data word carries one byte. The bytes arrive least significant first. The header names the target constant. The new 32-bit value replaces the old one in a single step, after the fourth byte has arrived. Until then, the selected output keeps using the old value.

Top module: `rnd_add`

## Requirements
- R1: While rst_ni is low, sum_o is 0, and every round register is cleared to 0.
- R2: When acc_i and sel_i are sampled at clock edge k, sum_o after edge k equals acc_i plus round register sel_i, as that register stood before edge k.
- R3: The addition wraps modulo 2^32. For example, 0xFFFFFFFF plus 2 gives 0x00000001.
- R4: While no write is in progress, a valid word with bits 11:6 equal to 100000 is a header, and it starts a write to the register whose address is in bits 3:0. Any other valid word received in that state is ignored.
- R5: After a header, the next four valid words are data words, and each carries one byte in bits 7:0. The first data word holds bits 7:0 of the new value and the fourth holds bits 31:24. Bits 11:8 of a data word are ignored.
- R6: The target register keeps its old value until the fourth data word is sampled. The whole new value takes effect at that same edge, and sum_o shows it one cycle later.
- R7: A word is taken only in a cycle where cfg_valid_i is high. Idle cycles may fall anywhere in a write sequence and do not disturb it.
- R8: When a register holding zero is selected, sum_o equals the accumulator value with no change.
- R9: A write changes only the addressed register. The other fifteen registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_valid_i | input | 1 | Configuration word valid |
| cfg_word_i | input | 12 | Configuration word (header or data) |
| sel_i | input | 4 | Selects the round register to add |
| acc_i | input | 32 | Accumulator result |
| sum_o | output | 32 | Registered sum of acc_i and the selected round register |

## Verification
The bench builds the block with its default parameters: sixteen registers, a 32-bit datapath and 8-bit data words. These values let the bench reach every register address, including the top one, 15. They also let it hit the carry out of bit 31 and observe the full four-byte write sequence. A behavioural model holds the register bank and a queue of pending bytes, and it predicts sum_o on every clock. Directed cases cover the following:
- reading a register partway through a write;
- data words with the reserved bits set;
- words that are not headers, and headers with the wrong tag;
- idle gaps inside a write.

// File: rtl/rnd_pkg.sv
package rnd_pkg;
  localparam int unsigned TAG_W = 6;
  localparam logic [TAG_W-1:0] HDR_TAG = 6'b100000;

  typedef enum logic {
    LD_IDLE = 1'b0,
    LD_DATA = 1'b1
  } ld_state_e;
endpackage

// File: rtl/rnd_cfg_loader.sv
module rnd_cfg_loader
  import rnd_pkg::*;
#(
  parameter int unsigned CFG_W  = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned N_REGS = 16,
  localparam int unsigned BYTES  = DATA_W / BYTE_W,
  localparam int unsigned CNT_W  = $clog2(BYTES),
  localparam int unsigned ADDR_W = $clog2(N_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_valid_i,
  input  logic [CFG_W-1:0]  cfg_word_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              busy_o
);
  ld_state_e                state_q;
  logic [CNT_W-1:0]         cnt_q;
  logic [ADDR_W-1:0]        addr_q;
  logic [DATA_W-BYTE_W-1:0] shadow_q;

  logic [BYTE_W-1:0] byte_in;
  logic              hdr_hit;
  logic              last_byte;

  assign byte_in   = cfg_word_i[BYTE_W-1:0];
  assign hdr_hit   = cfg_word_i[CFG_W-1 -: TAG_W] == HDR_TAG;
  assign last_byte = cnt_q == CNT_W'(BYTES - 1);

  // commit is combinational so the register file updates on the last-byte edge
  assign wr_en_o   = cfg_valid_i && (state_q == LD_DATA) && last_byte;
  assign wr_addr_o = addr_q;
  assign wr_data_o = {byte_in, shadow_q};
  assign busy_o    = state_q == LD_DATA;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= LD_IDLE;
      cnt_q    <= '0;
      addr_q   <= '0;
      shadow_q <= '0;
    end else if (cfg_valid_i) begin
      case (state_q)
        LD_IDLE: begin
          if (hdr_hit) begin
            state_q <= LD_DATA;
            addr_q  <= cfg_word_i[ADDR_W-1:0];
            cnt_q   <= '0;
          end
        end
        LD_DATA: begin
          if (last_byte) begin
            state_q <= LD_IDLE;
            cnt_q   <= '0;
          end else begin
            shadow_q[int'(cnt_q)*BYTE_W +: BYTE_W] <= byte_in;
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= LD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rnd_reg_file.sv
module rnd_reg_file #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_REGS = 16,
  localparam int unsigned ADDR_W = $clog2(N_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [N_REGS-1:0] wr_hit_o
);
  logic [DATA_W-1:0] regs_q [N_REGS];

  for (genvar i = 0; i < N_REGS; i++) begin : g_reg
    assign wr_hit_o[i] = wr_en_i && (wr_addr_i == ADDR_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          regs_q[i] <= '0;
      else if (wr_hit_o[i]) regs_q[i] <= wr_data_i;
    end
  end

  assign rd_data_o = regs_q[rd_sel_i];
endmodule

// File: rtl/rnd_sum.sv
module rnd_sum #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] rnd_i,
  output logic [DATA_W-1:0] sum_o
);
  // modulo 2^DATA_W, carry dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_o <= '0;
    else         sum_o <= acc_i + rnd_i;
  end
endmodule

// File: rtl/rnd_add.sv
module rnd_add #(
  parameter int unsigned CFG_W  = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned N_REGS = 16,
  localparam int unsigned ADDR_W = $clog2(N_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_valid_i,
  input  logic [CFG_W-1:0]  cfg_word_i,
  input  logic [ADDR_W-1:0] sel_i,
  input  logic [DATA_W-1:0] acc_i,
  output logic [DATA_W-1:0] sum_o
);
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rnd_val;
  logic [N_REGS-1:0] wr_hit;
  logic              ld_busy;

  rnd_cfg_loader #(
    .CFG_W (CFG_W),
    .DATA_W(DATA_W),
    .BYTE_W(BYTE_W),
    .N_REGS(N_REGS)
  ) u_loader (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_valid_i(cfg_valid_i),
    .cfg_word_i (cfg_word_i),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .busy_o     (ld_busy)
  );

  rnd_reg_file #(
    .DATA_W(DATA_W),
    .N_REGS(N_REGS)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .rd_sel_i (sel_i),
    .rd_data_o(rnd_val),
    .wr_hit_o (wr_hit)
  );

  rnd_sum #(
    .DATA_W(DATA_W)
  ) u_sum (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .acc_i (acc_i),
    .rnd_i (rnd_val),
    .sum_o (sum_o)
  );
endmodule

// File: rtl/rnd_add_chk.sv
module rnd_add_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_REGS = 16,
  localparam int unsigned ADDR_W = $clog2(N_REGS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_valid_i,
  input logic [ADDR_W-1:0] sel_i,
  input logic [DATA_W-1:0] acc_i,
  input logic [DATA_W-1:0] sum_o,
  input logic              wr_en,
  input logic [N_REGS-1:0] wr_hit,
  input logic              ld_busy
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  p_reset_clear_r1: assert property (@(posedge clk_i)
    !rst_ni |-> sum_o == '0);

  p_hold_sum_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && acc_i == $past(acc_i) && sel_i == $past(sel_i) && !$past(wr_en))
      |=> $stable(sum_o));

  p_commit_in_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> ld_busy);

  p_idle_after_commit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> !ld_busy);

  p_write_needs_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> cfg_valid_i);

  p_single_target_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_hit));
endmodule

bind rnd_add rnd_add_chk #(
  .DATA_W(DATA_W),
  .N_REGS(N_REGS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_valid_i(cfg_valid_i),
  .sel_i      (sel_i),
  .acc_i      (acc_i),
  .sum_o      (sum_o),
  .wr_en      (wr_en),
  .wr_hit     (wr_hit),
  .ld_busy    (ld_busy)
);

// File: tb/rnd_add_bench.sv
`timescale 1ns/1ps
module rnd_add_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_valid_i = 1'b0;
  logic [11:0] cfg_word_i = '0;
  logic [3:0]  sel_i = '0;
  logic [31:0] acc_i = '0;
  logic [31:0] sum_o;

  int n_tests = 0;
  int n_fails = 0;
  bit chk_en  = 1'b0;

  always #2 clk_i = ~clk_i;

  rnd_add u_rnd_add (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_valid_i(cfg_valid_i),
    .cfg_word_i (cfg_word_i),
    .sel_i      (sel_i),
    .acc_i      (acc_i),
    .sum_o      (sum_o)
  );

  // behavioural reference model
  logic [31:0] mdl_regs [16];
  logic [7:0]  pend_q [$];
  bit          mdl_loading;
  int          mdl_addr;
  logic [31:0] exp_sum;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      foreach (mdl_regs[i]) mdl_regs[i] = 32'h0;
      pend_q.delete();
      mdl_loading = 0;
      mdl_addr    = 0;
      exp_sum    <= 32'h0;
    end else begin
      exp_sum <= acc_i + mdl_regs[sel_i];
      if (cfg_valid_i) begin
        if (!mdl_loading) begin
          if (cfg_word_i[11:6] == 6'b100000) begin
            mdl_loading = 1;
            mdl_addr    = int'(cfg_word_i[3:0]);
            pend_q.delete();
          end
        end else begin
          pend_q.push_back(cfg_word_i[7:0]);
          if (pend_q.size() == 4) begin
            mdl_regs[mdl_addr] = {pend_q[3], pend_q[2], pend_q[1], pend_q[0]};
            pend_q.delete();
            mdl_loading = 0;
          end
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model (R2, R6)
  always @(negedge clk_i) begin
    if (chk_en) check(sum_o == exp_sum, "R2 model", sum_o, exp_sum);
  end

  task automatic cfg(input logic [11:0] w);
    @(negedge clk_i);
    cfg_valid_i = 1'b1;
    cfg_word_i  = w;
    @(negedge clk_i);
    cfg_valid_i = 1'b0;
  endtask

  task automatic load(input logic [3:0] addr, input logic [31:0] val,
                      input logic [3:0] rsv);
    cfg({8'h80, addr});
    for (int b = 0; b < 4; b++) cfg({rsv, val[b*8 +: 8]});
  endtask

  task automatic apply(input logic [31:0] acc, input logic [3:0] sel,
                       input logic [31:0] exp, input string req);
    @(negedge clk_i);
    acc_i = acc;
    sel_i = sel;
    @(negedge clk_i);
    check(sum_o == exp, req, sum_o, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fails++;
    $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fails);
    $finish;
  end

  initial begin
    acc_i = 32'h5555_AAAA;
    sel_i = 4'd3;
    repeat (3) @(negedge clk_i);
    check(sum_o == 32'h0, "R1 reset sum", sum_o, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_en = 1'b1;

    // R1: every register cleared
    for (int i = 0; i < 16; i++) apply(32'h0000_1234, 4'(i), 32'h0000_1234, "R1 cleared reg");

    // R5: byte order, LSB first
    load(4'd10, 32'h7654_3210, 4'h0);
    apply(32'h0, 4'd10, 32'h7654_3210, "R5 byte order");
    apply(32'h100, 4'd10, 32'h7654_3310, "R2 sum");

    // R3: wrap
    load(4'd5, 32'hFFFF_FFFF, 4'h0);
    apply(32'h2, 4'd5, 32'h0000_0001, "R3 wrap");

    // R5: reserved bits ignored
    load(4'd7, 32'hA1B2_C3D4, 4'hF);
    apply(32'h0, 4'd7, 32'hA1B2_C3D4, "R5 reserved bits");

    // R6: partial write not visible, then atomic commit
    cfg(12'h80A);
    cfg(12'h044);
    cfg(12'h033);
    cfg(12'h022);
    apply(32'h0, 4'd10, 32'h7654_3210, "R6 partial write hidden");
    cfg(12'h011);
    apply(32'h0, 4'd10, 32'h1122_3344, "R6 commit");

    // R4: foreign tags and stray data ignored when idle
    cfg(12'hC0A);
    cfg(12'h84A);
    for (int i = 0; i < 4; i++) cfg(12'h0FF);
    apply(32'h0, 4'd10, 32'h1122_3344, "R4 non-header ignored");

    // R4: top address
    load(4'd15, 32'h0BAD_F00D, 4'h0);
    apply(32'h1, 4'd15, 32'h0BAD_F00E, "R4 address 15");

    // R7: words without valid are ignored
    @(negedge clk_i);
    cfg_word_i = 12'h80A;
    @(negedge clk_i);
    cfg_word_i = 12'h0EE;
    repeat (4) @(negedge clk_i);
    cfg(12'h0AB);
    apply(32'h0, 4'd10, 32'h1122_3344, "R7 invalid ignored");

    // R9: neighbours untouched
    load(4'd3, 32'hDEAD_BEEF, 4'h0);
    apply(32'h0, 4'd3, 32'hDEAD_BEEF, "R9 target written");
    apply(32'h0, 4'd4, 32'h0, "R9 neighbour 4");
    apply(32'h0, 4'd10, 32'h1122_3344, "R9 neighbour 10");

    // R8: zero register passes acc through
    apply(32'h89AB_CDEF, 4'd0, 32'h89AB_CDEF, "R8 zero bypass");
    load(4'd3, 32'h0, 4'h0);
    apply(32'hFFFF_0000, 4'd3, 32'hFFFF_0000, "R8 reloaded zero");

    // R2: back-to-back changing operands, per-clock model compare
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      acc_i = 32'h1357_9BDF * (i + 1);
      sel_i = 4'(i * 7);
    end
    @(negedge clk_i);
    @(negedge clk_i);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fails);
    $finish;
  end
endmodule